// File: doc/BRIEF.md
# Set-Associative Injection Acceptance Unit

This unit sits beside the tag array of one node's attractive memory in a distributed shared memory machine with checkpoint-based recovery. It settles two questions for that memory. The first comes from another node that is trying to place a line here. Should the incoming line be taken, and into which way of its set? Or should it be passed on to another node? The second comes from this node's own replacement logic. Can a given line be dropped silently, or must it be injected elsewhere? While such an outgoing injection waits for the remote node's reply, the unit holds a lock on the line so that it is not replaced again.

The acceptance decision is a pure function of the presented set, which is registered into a one-cycle response. The outgoing side keeps a small table of pending injections, each identified by set and way. A table entry is released when the remote reply for that set and way arrives. Message transport and the data itself are handled outside the unit.

Top module: `inj_accept_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `acc_valid`, `acc_take` and `acc_fwd` are low and `lock_mask` is all zero. In that state an idle eviction port shows `ev_ready` high.
- R2: Line states are 3-bit codes: 0 Invalid, 1 Shared, 2 modified exclusive, 3 nonexclusive owner, 4 and 5 checkpointed-shared copies 1 and 2, 6 and 7 checkpointed-invalid copies 1 and 2. Way w occupies bits [3w+2:3w] of `in_ways`. The cycle after `in_valid` is sampled, `acc_valid` is high. If any unlocked way is Invalid, `acc_take` is high and `acc_way` is the lowest-numbered unlocked Invalid way.
- R3: With no unlocked Invalid way, an injection is taken into the lowest-numbered unlocked Shared way.
- R4: With no unlocked Invalid or Shared way, and the exception of R5 not applying, the injection is forwarded: `acc_fwd` is high and `acc_take` is low.
- R5: This requirement applies to an injected checkpointed-shared line (code 4 or 5) when `in_rd_pend` is high and way `in_rd_way` is unlocked. If R2 and R3 find no way, the line is taken into `in_rd_way`. An injected line of any other code is forwarded in the same situation.
- R6: A way whose outgoing injection is pending is never chosen as a victim.
- R7: If any way flagged in `in_same` holds a non-Invalid state, the injection is forwarded. This keeps an active copy and a recovery copy of one address out of one set.
- R8: An eviction of an Invalid or Shared line is silent. `ev_inject` stays low and no lock is created.
- R9: An eviction of a line with code 2 to 7 raises `ev_inject` in the same cycle. From the next cycle on, the lock bit of that way shows in `lock_mask` whenever `in_set` equals the eviction set.
- R10: While PEND injections are pending, an eviction that needs an injection sees `ev_ready` low. A silent eviction is still accepted.
- R11: An eviction of a line whose own injection is pending sees `ev_ready` low.
- R12: A `done_valid` pulse naming a pending set and way clears that lock from the next cycle, and frees one slot of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming injection request present |
| in_set | input | SET_W | Set index of the incoming line; also selects `lock_mask` |
| in_state | input | 3 | State code of the injected line |
| in_ways | input | 3*WAYS | State codes of the ways in that set |
| in_same | input | WAYS | Ways holding the same address as the injected line |
| in_rd_pend | input | 1 | A read of the injected line is outstanding here |
| in_rd_way | input | WAY_W | Way reserved for that outstanding read |
| acc_valid | output | 1 | Decision present |
| acc_take | output | 1 | Injection accepted |
| acc_fwd | output | 1 | Injection to be forwarded |
| acc_way | output | WAY_W | Victim way when accepted |
| lock_mask | output | WAYS | Ways of `in_set` with a pending outgoing injection |
| ev_req | input | 1 | Local replacement request |
| ev_set | input | SET_W | Set of the line to replace |
| ev_way | input | WAY_W | Way of the line to replace |
| ev_state | input | 3 | State code of the line to replace |
| ev_ready | output | 1 | Replacement may proceed this cycle |
| ev_inject | output | 1 | Replacement granted and needs an injection |
| done_valid | input | 1 | Remote reply closing an outgoing injection |
| done_set | input | SET_W | Set of the closed injection |
| done_way | input | WAY_W | Way of the closed injection |

## Verification
The acceptance result is registered, so it is due exactly one clock after `in_valid` is sampled. The bench drives each request on a falling edge and reads `acc_*` on the next falling edge. `ev_ready` and `ev_inject` are combinational, and are read a moment after the inputs change, before the edge that commits them. A lock created or freed at an edge shows in `lock_mask` on the falling edge that follows. Each lock check therefore sets `in_set` first and then reads the mask after that edge.

// File: rtl/inj_accept_unit.sv
module inj_accept_unit #(
  parameter int WAYS  = 4,
  parameter int SET_W = 6,
  parameter int PEND  = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PID_W = (PEND > 1) ? $clog2(PEND) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SET_W-1:0]   in_set,
  input  logic [2:0]         in_state,
  input  logic [3*WAYS-1:0]  in_ways,
  input  logic [WAYS-1:0]    in_same,
  input  logic               in_rd_pend,
  input  logic [WAY_W-1:0]   in_rd_way,
  output logic               acc_valid,
  output logic               acc_take,
  output logic               acc_fwd,
  output logic [WAY_W-1:0]   acc_way,
  output logic [WAYS-1:0]    lock_mask,
  input  logic               ev_req,
  input  logic [SET_W-1:0]   ev_set,
  input  logic [WAY_W-1:0]   ev_way,
  input  logic [2:0]         ev_state,
  output logic               ev_ready,
  output logic               ev_inject,
  input  logic               done_valid,
  input  logic [SET_W-1:0]   done_set,
  input  logic [WAY_W-1:0]   done_way
);

  localparam logic [2:0] ST_INV = 3'd0;
  localparam logic [2:0] ST_SHR = 3'd1;
  localparam logic [2:0] ST_CS1 = 3'd4;
  localparam logic [2:0] ST_CS2 = 3'd5;

  logic [PEND-1:0]  pv;
  logic [SET_W-1:0] pset [PEND];
  logic [WAY_W-1:0] pway [PEND];

  logic             ev_locked, ev_needs, full;
  logic [PID_W-1:0] free_idx;
  logic             inv_hit, shr_hit, conflict, sck_ok;
  logic [WAY_W-1:0] inv_way, shr_way;
  logic             take_d;
  logic [WAY_W-1:0] way_d;

  always_comb begin
    lock_mask = '0;
    ev_locked = 1'b0;
    free_idx  = '0;
    for (int p = PEND - 1; p >= 0; p--) begin
      if (pv[p] && pset[p] == in_set) lock_mask[pway[p]] = 1'b1;
      if (pv[p] && pset[p] == ev_set && pway[p] == ev_way) ev_locked = 1'b1;
      if (!pv[p]) free_idx = PID_W'(p);
    end
  end

  assign full      = &pv;
  assign ev_needs  = (ev_state != ST_INV) && (ev_state != ST_SHR);
  assign ev_ready  = !ev_locked && (!ev_needs || !full);
  assign ev_inject = ev_req && ev_ready && ev_needs;

  always_comb begin
    inv_hit  = 1'b0;
    shr_hit  = 1'b0;
    conflict = 1'b0;
    inv_way  = '0;
    shr_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (in_same[w] && in_ways[3*w +: 3] != ST_INV) conflict = 1'b1;
      if (!lock_mask[w] && in_ways[3*w +: 3] == ST_INV) begin
        inv_hit = 1'b1;
        inv_way = WAY_W'(w);
      end
      if (!lock_mask[w] && in_ways[3*w +: 3] == ST_SHR) begin
        shr_hit = 1'b1;
        shr_way = WAY_W'(w);
      end
    end
  end

  assign sck_ok = in_rd_pend && (in_state == ST_CS1 || in_state == ST_CS2)
                  && !lock_mask[in_rd_way];

  always_comb begin
    take_d = 1'b0;
    way_d  = '0;
    if (!conflict) begin
      if (inv_hit) begin
        take_d = 1'b1;
        way_d  = inv_way;
      end else if (shr_hit) begin
        take_d = 1'b1;
        way_d  = shr_way;
      end else if (sck_ok) begin
        take_d = 1'b1;
        way_d  = in_rd_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_take  <= 1'b0;
      acc_fwd   <= 1'b0;
      acc_way   <= '0;
    end else begin
      acc_valid <= in_valid;
      acc_take  <= in_valid && take_d;
      acc_fwd   <= in_valid && !take_d;
      acc_way   <= take_d ? way_d : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int p = 0; p < PEND; p++) begin
        pset[p] <= '0;
        pway[p] <= '0;
      end
    end else begin
      for (int p = 0; p < PEND; p++) begin
        if (done_valid && pv[p] && pset[p] == done_set && pway[p] == done_way)
          pv[p] <= 1'b0;
        if (ev_inject && free_idx == PID_W'(p)) begin
          pv[p]   <= 1'b1;
          pset[p] <= ev_set;
          pway[p] <= ev_way;
        end
      end
    end
  end

  // R2
  decision_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> acc_valid);

  // R4
  take_fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_take ^ acc_fwd));

  // R6
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_take) |-> ((($past(lock_mask) >> acc_way) & WAYS'(1)) == '0));

  // R8
  silent_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req && !ev_needs && !done_valid) |=> $stable(pv));

  // R9
  inject_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inject && !done_valid) |=> ($countones(pv) == $past($countones(pv)) + 1));

  // R10
  table_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(ev_req && ev_needs && ev_inject));

endmodule

// File: tb/inj_accept_unit_test.sv
module inj_accept_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4;
  localparam int SET_W = 6;
  localparam int WAY_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [SET_W-1:0] in_set = '0;
  logic [2:0] in_state = '0;
  logic [3*WAYS-1:0] in_ways = '0;
  logic [WAYS-1:0] in_same = '0;
  logic in_rd_pend = 1'b0;
  logic [WAY_W-1:0] in_rd_way = '0;
  logic acc_valid, acc_take, acc_fwd;
  logic [WAY_W-1:0] acc_way;
  logic [WAYS-1:0] lock_mask;
  logic ev_req = 1'b0;
  logic [SET_W-1:0] ev_set = '0;
  logic [WAY_W-1:0] ev_way = '0;
  logic [2:0] ev_state = '0;
  logic ev_ready, ev_inject;
  logic done_valid = 1'b0;
  logic [SET_W-1:0] done_set = '0;
  logic [WAY_W-1:0] done_way = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inj_accept_unit #(.WAYS(WAYS), .SET_W(SET_W), .PEND(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_set(in_set), .in_state(in_state), .in_ways(in_ways),
    .in_same(in_same), .in_rd_pend(in_rd_pend), .in_rd_way(in_rd_way),
    .acc_valid(acc_valid), .acc_take(acc_take), .acc_fwd(acc_fwd), .acc_way(acc_way),
    .lock_mask(lock_mask),
    .ev_req(ev_req), .ev_set(ev_set), .ev_way(ev_way), .ev_state(ev_state),
    .ev_ready(ev_ready), .ev_inject(ev_inject),
    .done_valid(done_valid), .done_set(done_set), .done_way(done_way));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ws(input int s3, input int s2, input int s1, input int s0);
    return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endfunction

  // drives an injection; exp_way < 0 means forward expected
  task automatic inject(input string req, input int set, input int st, input logic [11:0] wv,
                        input logic [3:0] same, input bit rd, input int rdw, input int exp_way);
    @(negedge clk);
    in_valid = 1'b1; in_set = SET_W'(set); in_state = 3'(st); in_ways = wv;
    in_same = same; in_rd_pend = rd; in_rd_way = WAY_W'(rdw);
    @(negedge clk);
    in_valid = 1'b0; in_rd_pend = 1'b0; in_same = '0;
    check(acc_valid == 1'b1, req, int'(acc_valid), 1);
    if (exp_way < 0) begin
      check(acc_fwd && !acc_take, req, int'({acc_take, acc_fwd}), 1);
    end else begin
      check(acc_take && !acc_fwd, req, int'({acc_take, acc_fwd}), 2);
      check(int'(acc_way) == exp_way, req, int'(acc_way), exp_way);
    end
  endtask

  task automatic evict(input string req, input int set, input int way, input int st,
                       input bit exp_ready, input bit exp_inj);
    @(negedge clk);
    ev_req = 1'b1; ev_set = SET_W'(set); ev_way = WAY_W'(way); ev_state = 3'(st);
    #1;
    check(ev_ready == exp_ready, req, int'(ev_ready), int'(exp_ready));
    check(ev_inject == exp_inj, req, int'(ev_inject), int'(exp_inj));
    @(posedge clk);
    #1 ev_req = 1'b0;
  endtask

  task automatic locks(input string req, input int set, input int exp);
    @(negedge clk);
    in_set = SET_W'(set);
    #1;
    check(int'(lock_mask) == exp, req, int'(lock_mask), exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!acc_valid && !acc_take && !acc_fwd, "R1", int'({acc_valid, acc_take, acc_fwd}), 0);
    check(lock_mask == '0, "R1", int'(lock_mask), 0);
    check(ev_ready == 1'b1, "R1", int'(ev_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!acc_valid, "R1", int'(acc_valid), 0);
  endtask

  task automatic t_pick();
    inject("R2", 3, 2, ws(0, 1, 0, 2), 4'b0, 0, 0, 1);
    inject("R2", 3, 1, ws(0, 0, 0, 0), 4'b0, 0, 0, 0);
    inject("R3", 3, 2, ws(1, 1, 6, 4), 4'b0, 0, 0, 2);
    inject("R4", 3, 2, ws(7, 5, 3, 2), 4'b0, 0, 0, -1);
  endtask

  task automatic t_sck_read();
    inject("R5", 4, 4, ws(6, 5, 3, 2), 4'b0, 1, 3, 3);
    inject("R5", 4, 5, ws(6, 5, 3, 2), 4'b0, 1, 1, 1);
    inject("R5", 4, 2, ws(6, 5, 3, 2), 4'b0, 1, 3, -1);
    inject("R5", 4, 4, ws(1, 5, 3, 2), 4'b0, 1, 0, 3);
  endtask

  task automatic t_conflict();
    inject("R7", 8, 4, ws(0, 2, 0, 0), 4'b0100, 0, 0, -1);
    inject("R7", 8, 4, ws(0, 2, 0, 0), 4'b0001, 0, 0, 0);
  endtask

  task automatic t_evict_lock();
    evict("R8", 5, 1, 1, 1, 0);
    locks("R8", 5, 0);
    evict("R9", 5, 0, 2, 1, 1);
    locks("R9", 5, 4'b0001);
    locks("R9", 6, 0);
    inject("R6", 5, 1, ws(0, 0, 0, 0), 4'b0, 0, 0, 1);
    inject("R6", 5, 4, ws(2, 2, 2, 1), 4'b0, 1, 0, -1);
    evict("R11", 5, 0, 2, 0, 0);
  endtask

  task automatic t_full();
    evict("R10", 7, 0, 3, 1, 1);
    evict("R10", 7, 1, 4, 1, 1);
    evict("R10", 7, 2, 6, 1, 1);
    locks("R10", 7, 4'b0111);
    evict("R10", 9, 0, 7, 0, 0);
    evict("R10", 9, 0, 1, 1, 0);
  endtask

  task automatic t_done();
    @(negedge clk);
    done_valid = 1'b1; done_set = SET_W'(5); done_way = WAY_W'(0);
    @(negedge clk);
    done_valid = 1'b0;
    locks("R12", 5, 0);
    evict("R12", 9, 0, 7, 1, 1);
    locks("R12", 9, 4'b0001);
    locks("R12", 7, 4'b0111);
  endtask

  initial begin
    t_reset();
    t_pick();
    t_sck_read();
    t_conflict();
    t_evict_lock();
    t_full();
    t_done();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule